// File: doc/BRIEF.md
# Back-to-Back Instruction Dependency Detector

This block decides whether an instruction entering execution depends on the instruction that completed just before it. Decode logic upstream turns each instruction into a compact operand descriptor. The detector compares the descriptor of the previous instruction with the descriptor of the current one and raises a single dependency bit. Issue logic and hazard counters can then use that bit to hold back pairing, to insert a stall, or to gather statistics.

Each descriptor holds `NUM_OPS` operand slots. A slot names a register and says whether the operand is an immediate, a plain register, or a base register plus displacement (a memory access). A slot can also be unused. A marker bit flags the destination operand. Two further bits record whether the instruction writes or reads the condition flag. The rules are not a plain match of register numbers. A memory destination followed by a memory source is always dependent, so that a store completes before a later load. A memory destination never blocks a plain register read. On the current instruction, the base register of a memory destination is treated as a read.

The `REGISTERED` parameter chooses the output stage. When it is 0, the result is combinational. When it is 1, the result comes out of one flop that clears on reset.

Top module: `bb_dep_detect`

## Requirements
- R1: When the previous instruction writes the condition flag (bit 8N of its descriptor) and the current one reads it (bit 8N+1), the result is dependent whatever the operands are. A flag write alone, with no flag read, does not make the result dependent.
- R2: When the previous instruction has no usable destination slot and R1 does not apply, the result is not dependent.
- R3: A current slot of kind immediate never causes a dependency, even if its register field equals the previous destination.
- R4: A previous plain-register destination followed by a current plain-register source is dependent exactly when the two register numbers are equal. This holds for every slot position.
- R5: A previous memory destination followed by a current plain-register source is never dependent, even when the register numbers are equal.
- R6: A previous plain-register destination followed by a current memory operand is dependent exactly when the destination register equals that operand's base register.
- R7: A previous memory destination followed by any current memory operand is dependent, whatever the register numbers are.
- R8: On the current instruction, a memory-kind destination slot takes part in the comparison as a source through its base register. A plain-register destination slot does not take part.
- R9: Descriptor layout, with N = 3 and 5-bit registers: slot i occupies bits 8i+7 down to 8i, arranged as {dst marker, kind[1:0], reg[4:0]}. The kind codes are 00 immediate, 01 plain register, 10 memory (base plus displacement) and 11 unused. Unused slots never create a dependency and never supply a destination. The previous destination is taken from the lowest-index slot that carries the marker and has kind 01 or 10.
- R10: With REGISTERED=1, the output shows the result for the inputs present at the previous rising clock edge, and it is 0 while reset (active low) is held. With REGISTERED=0, the output follows the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output flop |
| rst_n | input | 1 | Active-low synchronous reset |
| prev_desc | input | NUM_OPS*(REG_W+3)+2 | Descriptor of the previously completed instruction |
| cur_desc | input | NUM_OPS*(REG_W+3)+2 | Descriptor of the current instruction |
| dep_o | output | 1 | Dependency result |

## Verification
The bench targets the pairs where a plain register-number match gives the wrong answer, and checks what a faulty design would do in each one.
- A store base that equals a later plain read: a naive comparator would flag a false hazard here.
- Two memory accesses with unrelated bases: a design that ignores the store-before-load ordering would report them as independent.
- A current store whose base register is the previous destination: the hazard is missed if memory destinations are not treated as reads.
- An immediate or unused slot that carries a matching register field, and a destination marker placed on an unused slot: a design that ignores slot kinds gives spurious or misplaced hits.
- The flag rule in both directions.

Both output variants are checked. The registered one is checked for its one-cycle lag and for being held at 0 during reset.

// File: rtl/bbd_pkg.sv
package bbd_pkg;

   // Operand slot kinds; the code values are part of the descriptor layout.
   typedef enum logic [1:0] {
      OPK_IMM  = 2'b00,
      OPK_REG  = 2'b01,
      OPK_DISP = 2'b10,
      OPK_NONE = 2'b11
   } opk_e;

   localparam int KIND_W = 2;

endpackage

// File: rtl/bbd_dst_pick.sv
module bbd_dst_pick
   import bbd_pkg::*;
#(
   parameter int NUM_OPS = 3,
   parameter int REG_W   = 5
) (
   input  logic [NUM_OPS*(REG_W+3)-1:0] slots,
   output logic                         has_dst,
   output logic                         dst_disp,
   output logic [REG_W-1:0]             dst_reg
);
   localparam int SLOT_W = REG_W + KIND_W + 1;
   localparam int MARK_B = REG_W + KIND_W;

   // Scan from the top down so that the lowest qualifying slot wins.
   always_comb begin
      has_dst  = 1'b0;
      dst_disp = 1'b0;
      dst_reg  = '0;
      for (int i = NUM_OPS - 1; i >= 0; i--) begin
         if (slots[i*SLOT_W + MARK_B] &&
             ((slots[i*SLOT_W + REG_W +: KIND_W] == OPK_REG) ||
              (slots[i*SLOT_W + REG_W +: KIND_W] == OPK_DISP))) begin
            has_dst  = 1'b1;
            dst_disp = (slots[i*SLOT_W + REG_W +: KIND_W] == OPK_DISP);
            dst_reg  = slots[i*SLOT_W +: REG_W];
         end
      end
   end

endmodule

// File: rtl/bbd_src_match.sv
module bbd_src_match
   import bbd_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [REG_W+2:0]   slot,
   input  logic               has_dst,
   input  logic               dst_disp,
   input  logic [REG_W-1:0]   dst_reg,
   output logic               hit
);
   opk_e             kind;
   logic             is_dst;
   logic [REG_W-1:0] num;
   logic             as_src;

   assign kind   = opk_e'(slot[REG_W +: KIND_W]);
   assign is_dst = slot[REG_W + KIND_W];
   assign num    = slot[REG_W-1:0];

   // Memory operands always read their base; plain registers only when not written.
   assign as_src = ((kind == OPK_REG) && !is_dst) || (kind == OPK_DISP);

   always_comb begin
      hit = 1'b0;
      if (has_dst && as_src) begin
         if (dst_disp) hit = (kind == OPK_DISP);
         else          hit = (num == dst_reg);
      end
   end

   AST_IMM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == OPK_IMM) |-> !hit); // R3
   AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == OPK_NONE) |-> !hit); // R9
   AST_MEM_DST_SHIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (has_dst && dst_disp && kind == OPK_REG) |-> !hit); // R5
   AST_MEM_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (has_dst && dst_disp && kind == OPK_DISP) |-> hit); // R7
   AST_REG_DST_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == OPK_REG && is_dst) |-> !hit); // R8

endmodule

// File: rtl/bbd_out_stage.sv
module bbd_out_stage #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (REGISTERED) begin : g_flop
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= d;
         end

         AST_LAG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            d |=> q); // R10
         AST_LAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !d |=> !q); // R10
      end else begin : g_wire
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/bb_dep_detect.sv
module bb_dep_detect
   import bbd_pkg::*;
#(
   parameter int NUM_OPS    = 3,
   parameter int REG_W      = 5,
   parameter bit REGISTERED = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_OPS*(REG_W+3)+1:0]   prev_desc,
   input  logic [NUM_OPS*(REG_W+3)+1:0]   cur_desc,
   output logic                           dep_o
);
   localparam int SLOT_W = REG_W + KIND_W + 1;
   localparam int OPS_W  = NUM_OPS * SLOT_W;
   localparam int WR_BIT = OPS_W;
   localparam int RD_BIT = OPS_W + 1;

   generate
      if (NUM_OPS < 1 || NUM_OPS > 8) begin : g_bad_ops
         $error("bb_dep_detect: NUM_OPS must lie in 1..8");
      end
      if (REG_W < 1 || REG_W > 8) begin : g_bad_reg
         $error("bb_dep_detect: REG_W must lie in 1..8");
      end
   endgenerate

   logic               has_dst;
   logic               dst_disp;
   logic [REG_W-1:0]   dst_reg;
   logic [NUM_OPS-1:0] slot_hit;
   logic               flag_hit;
   logic               dep_now;

   bbd_dst_pick #(.NUM_OPS(NUM_OPS), .REG_W(REG_W)) u_pick (
      .slots    (prev_desc[OPS_W-1:0]),
      .has_dst  (has_dst),
      .dst_disp (dst_disp),
      .dst_reg  (dst_reg)
   );

   generate
      for (genvar g = 0; g < NUM_OPS; g++) begin : g_slot
         bbd_src_match #(.REG_W(REG_W)) u_match (
            .clk      (clk),
            .rst_n    (rst_n),
            .slot     (cur_desc[g*SLOT_W +: SLOT_W]),
            .has_dst  (has_dst),
            .dst_disp (dst_disp),
            .dst_reg  (dst_reg),
            .hit      (slot_hit[g])
         );
      end
   endgenerate

   assign flag_hit = prev_desc[WR_BIT] & cur_desc[RD_BIT];
   assign dep_now  = flag_hit | (|slot_hit);

   bbd_out_stage #(.REGISTERED(REGISTERED)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (dep_now),
      .q     (dep_o)
   );

   AST_FLAG_FORCES_DEP: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_desc[WR_BIT] && cur_desc[RD_BIT]) |-> dep_now); // R1
   AST_NO_DST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!has_dst && !(prev_desc[WR_BIT] && cur_desc[RD_BIT])) |-> !dep_now); // R2
   AST_DST_FROM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      !has_dst |-> !(|slot_hit)); // R9

endmodule

// File: tb/tb_bb_dep_detect.sv
module tb_bb_dep_detect;

   localparam int DW = 26;
   localparam logic [1:0] K_IMM = 2'b00, K_REG = 2'b01, K_MEM = 2'b10, K_NIL = 2'b11;
   localparam logic [7:0] NIL = 8'h60;

   function automatic logic [7:0] op(input logic d, input logic [1:0] k, input logic [4:0] r);
      return {d, k, r};
   endfunction

   function automatic logic [DW-1:0] ds(input logic rf, input logic wf,
                                        input logic [7:0] o2, input logic [7:0] o1,
                                        input logic [7:0] o0);
      return {rf, wf, o2, o1, o0};
   endfunction

   // {prev, cur, expected, requirement number}
   localparam int NV = 17;
   localparam logic [2*DW+4:0] VEC [NV] = '{
      {ds(0,0,NIL,op(0,K_REG,1),op(1,K_REG,3)), ds(0,0,NIL,NIL,op(0,K_REG,3)), 1'b1, 4'd4},              // R4 match
      {ds(0,0,NIL,op(0,K_REG,1),op(1,K_REG,3)), ds(0,0,NIL,op(0,K_IMM,9),op(0,K_REG,4)), 1'b0, 4'd4},    // R4 differ
      {ds(0,0,NIL,op(0,K_REG,5),op(1,K_MEM,3)), ds(0,0,NIL,NIL,op(0,K_REG,3)), 1'b0, 4'd5},              // R5
      {ds(0,0,NIL,NIL,op(1,K_REG,7)), ds(0,0,NIL,op(0,K_MEM,7),op(1,K_REG,2)), 1'b1, 4'd6},              // R6 base match
      {ds(0,0,NIL,NIL,op(1,K_REG,7)), ds(0,0,NIL,op(0,K_MEM,8),op(1,K_REG,2)), 1'b0, 4'd6},              // R6 base differs
      {ds(0,0,NIL,op(0,K_REG,4),op(1,K_MEM,1)), ds(0,0,NIL,op(0,K_MEM,9),op(1,K_REG,2)), 1'b1, 4'd7},    // R7 store then load
      {ds(0,0,NIL,NIL,op(1,K_REG,6)), ds(0,0,NIL,op(0,K_REG,1),op(1,K_MEM,6)), 1'b1, 4'd8},              // R8 store base
      {ds(0,0,NIL,NIL,op(1,K_REG,6)), ds(0,0,NIL,op(0,K_REG,1),op(1,K_REG,6)), 1'b0, 4'd8},              // R8 reg dst
      {ds(0,0,op(0,K_REG,3),op(0,K_IMM,3),op(0,K_REG,3)), ds(1,0,NIL,NIL,op(0,K_REG,3)), 1'b0, 4'd2},    // R2
      {ds(0,1,op(0,K_REG,3),op(0,K_IMM,3),op(0,K_REG,3)), ds(1,0,NIL,NIL,op(0,K_IMM,0)), 1'b1, 4'd1},    // R1 flag pair
      {ds(0,1,NIL,NIL,op(1,K_REG,12)), ds(0,0,NIL,NIL,op(0,K_REG,13)), 1'b0, 4'd1},                      // R1 write only
      {ds(0,0,NIL,NIL,op(1,K_REG,10)), ds(0,0,NIL,op(0,K_IMM,10),op(1,K_REG,1)), 1'b0, 4'd3},            // R3
      {ds(0,0,NIL,NIL,op(1,K_REG,10)), ds(0,0,NIL,op(0,K_NIL,10),op(0,K_REG,11)), 1'b0, 4'd9},           // R9 unused src
      {ds(0,0,NIL,op(1,K_REG,5),op(1,K_NIL,4)), ds(0,0,NIL,NIL,op(0,K_REG,4)), 1'b0, 4'd9},              // R9 unused dst
      {ds(0,0,NIL,op(1,K_REG,5),op(1,K_NIL,4)), ds(0,0,NIL,NIL,op(0,K_REG,5)), 1'b1, 4'd9},              // R9 next dst
      {ds(0,0,op(1,K_REG,31),op(0,K_REG,1),op(0,K_REG,2)), ds(0,0,op(0,K_REG,31),NIL,NIL), 1'b1, 4'd4},  // R4 top slot
      {ds(0,0,NIL,op(0,K_REG,3),op(1,K_MEM,1)), ds(0,0,NIL,op(0,K_REG,3),op(1,K_MEM,2)), 1'b1, 4'd7}     // R7 store then store
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] prev_d = '0;
   logic [DW-1:0] cur_d = '0;
   logic          dep_r;
   logic          dep_c;
   int            n_chk = 0;
   int            n_bad = 0;
   bit            done = 1'b0;

   always #5 clk = ~clk;

   bb_dep_detect #(.NUM_OPS(3), .REG_W(5), .REGISTERED(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .prev_desc(prev_d), .cur_desc(cur_d), .dep_o(dep_r));

   bb_dep_detect #(.NUM_OPS(3), .REG_W(5), .REGISTERED(1'b0)) dut_c (
      .clk(clk), .rst_n(rst_n), .prev_desc(prev_d), .cur_desc(cur_d), .dep_o(dep_c));

   task automatic check(input string what, input int req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: got %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
   end

   initial begin
      // R10: the registered output stays low under reset even with a flag pair present.
      @(negedge clk);
      prev_d = ds(0,1,NIL,NIL,NIL);
      cur_d  = ds(1,0,NIL,NIL,NIL);
      @(posedge clk); @(posedge clk); #1;
      check("reset hold registered", 10, dep_r, 1'b0);
      check("reset comb path", 10, dep_c, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("first edge after reset", 10, dep_r, 1'b1);

      // Vector table: combinational result in the same cycle, registered one edge later.
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         prev_d = VEC[i][2*DW+4 -: DW];
         cur_d  = VEC[i][DW+4 -: DW];
         #1;
         check($sformatf("vec %0d comb", i), int'(VEC[i][3:0]), dep_c, VEC[i][4]);
         @(posedge clk); #1;
         check($sformatf("vec %0d registered", i), int'(VEC[i][3:0]), dep_r, VEC[i][4]);
      end

      // R10 latency: the registered output holds the old result until the next edge.
      @(negedge clk);
      prev_d = ds(0,0,NIL,NIL,op(1,K_REG,20));
      cur_d  = ds(0,0,NIL,NIL,op(0,K_REG,20));
      @(posedge clk); #1;
      check("lag setup", 10, dep_r, 1'b1);
      @(negedge clk);
      cur_d = ds(0,0,NIL,NIL,op(0,K_REG,21));
      #1;
      check("lag comb immediate", 10, dep_c, 1'b0);
      check("lag registered holds", 10, dep_r, 1'b1);
      @(posedge clk); #1;
      check("lag registered updates", 10, dep_r, 1'b0);

      // R10: reset asserted mid-run clears the registered output.
      @(negedge clk);
      cur_d = ds(0,0,NIL,NIL,op(0,K_REG,20));
      rst_n = 1'b0;
      @(posedge clk); #1;
      check("reset mid-run", 10, dep_r, 1'b0);
      finish_run();
   end

endmodule